// File: doc/BRIEF.md
# Cartesian Coded I/Q Digital Upconverter

This block is the last digital stage of a Cartesian constant-envelope transmitter. It takes two one-bit streams that low-pass coders produce for the in-phase and quadrature parts of the baseband signal. In each stream a 1 stands for +a and a 0 for -a. The block places the two streams on quadrature phases of a digital carrier. The result is a single two-level bitstream at four times the carrier rate, which drives a switched-mode power amplifier. There is no analog mixer. The carrier sign is applied with an XOR gate, and the carrier phase sequence selects either the I bit or the Q bit.

One clock runs everything. It is the RF-rate clock, at four times the carrier frequency. The carrier phase, the carrier-period count and the coder sample boundary all come from counters on this clock, so the carrier and the coded data cannot drift apart. A `sync` pulse puts both counters at a known point, which fixes the alignment between carrier and data. The parameter `SAMPLE_DIV` sets how many carrier periods make up one coder sample. With the default value of 1, the coder sample rate equals the carrier frequency.

Top module: `qmix_upconv`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rf_bit` becomes 0 and `phase_idx` becomes 0.
- R2: On every enabled edge without `sync`, the carrier phase advances by one through 0,1,2,3 and wraps to 0. `phase_idx` reports the phase of the bit currently on `rf_bit`.
- R3: An enabled edge with `sync` high is treated as carrier phase 0 of carrier period 0, whatever the counters held before.
- R4: The output bit for each phase is as follows, with 1 meaning +a: phase 0 gives I, phase 1 gives Q, phase 2 gives NOT I, phase 3 gives NOT Q.
- R5: A new I/Q pair takes effect only at a sample boundary, which is phase 0 of carrier period 0. A pair strobed at any other edge is held until the next boundary. A pair strobed on the boundary edge itself is used at once.
- R6: One coder sample lasts `SAMPLE_DIV` carrier periods. A pair strobed inside a sample first appears at phase 0 of the next period 0.
- R7: At an edge with `en` low, `rf_bit` becomes 0, and `phase_idx` and both counters hold. `sync` is ignored.
- R8: Within any carrier period produced by four consecutive enabled edges, the bit at phase 2 is the complement of the bit at phase 0, so every period holds exactly two ones.
- R9: `rf_bit` is registered. The bit for a phase appears one clock after the edge at which its inputs were sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | RF-rate clock, four times the carrier frequency |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; when low, the output is 0 and the counters hold |
| sync | input | 1 | Forces the current edge to phase 0 of carrier period 0 |
| strobe | input | 1 | Marks a valid coded I/Q pair on `i_bit`/`q_bit` |
| i_bit | input | 1 | Coded in-phase bit (1 = +a, 0 = -a) |
| q_bit | input | 1 | Coded quadrature bit (1 = +a, 0 = -a) |
| rf_bit | output | 1 | Two-level RF-rate output bit |
| phase_idx | output | 2 | Carrier phase of the bit on `rf_bit` |

## Verification
The hardest case to reach is a coded pair that arrives in the middle of a carrier period, or in the middle of a multi-period sample. The output must keep using the old pair until the boundary, which the ports never flag directly. The stimulus syncs first to fix the phase. It then strobes a pair that differs in both bits at phase 1. The values at phases 1 to 3 show whether the old pair was held, and the following phase 0 shows the new pair. For a divider of three, the output is checked at each of the two intermediate phase-0 points and then at the real boundary. A sync issued at phase 2, together with a strobe, checks realignment and immediate use of the strobed pair.

// File: rtl/qmix_pkg.sv
// Shared types and the gate-level mixing function for the I/Q upconverter.
package qmix_pkg;

    // Carrier phase index: one step per RF clock, four per carrier period.
    typedef logic [1:0] qphase_t;

    localparam qphase_t PH_ZERO = 2'd0;
    localparam qphase_t PH_LAST = 2'd3;

    // Digital mixing: phase bit 0 picks the I or Q branch, and phase bit 1
    // is the carrier sign, applied with an XOR instead of a multiplier.
    function automatic logic mix_bit(input qphase_t ph, input logic di, input logic dq);
        logic branch;
        branch = ph[0] ? dq : di;
        return branch ^ ph[1];
    endfunction

endpackage

// File: rtl/qmix_phase_gen.sv
// Carrier phase and carrier-period counters.
// Assumes one RF clock per quarter carrier period. Both counters advance only
// while enabled. Sync forces the present edge to phase 0 of period 0.
module qmix_phase_gen #(
    parameter int SAMPLE_DIV = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sync,
    output qmix_pkg::qphase_t eff_phase,
    output logic              sample_edge
);
    import qmix_pkg::*;

    localparam int CW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
    localparam logic [CW-1:0] PER_LAST = CW'(SAMPLE_DIV - 1);

    qphase_t       ph_q;
    logic [CW-1:0] per_q;
    logic [CW-1:0] eff_per;

    // Effective position for this edge, with sync overriding the counters.
    always_comb begin
        eff_phase   = (en && sync) ? PH_ZERO : ph_q;
        eff_per     = (en && sync) ? '0 : per_q;
        sample_edge = en && (eff_phase == PH_ZERO) && (eff_per == '0);
    end

    // Advance the phase, and the period count at the end of each carrier period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_ZERO;
            per_q <= '0;
        end else if (en) begin
            ph_q <= qphase_t'(eff_phase + 2'd1);
            if (eff_phase == PH_LAST)
                per_q <= (eff_per == PER_LAST) ? '0 : eff_per + 1'b1;
            else
                per_q <= eff_per;
        end
    end

    // R6: the period count never leaves its range.
    a_r6_period_range: assert property (@(posedge clk) disable iff (!rst_n)
        per_q <= PER_LAST);

endmodule

// File: rtl/qmix_sample_latch.sv
// Holds the coded I/Q pair in use and the last strobed pair waiting for the
// next sample boundary. Assumes load is high only on boundary edges.
// cur_i/cur_q give the pair that applies at the present edge.
module qmix_sample_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic i_in,
    input  logic q_in,
    input  logic load,
    output logic cur_i,
    output logic cur_q
);
    logic pend_i, pend_q;
    logic act_i, act_q;
    logic nxt_i, nxt_q;

    // Pair that would be taken at a boundary, with a fresh strobe first.
    always_comb begin
        nxt_i = strobe ? i_in : pend_i;
        nxt_q = strobe ? q_in : pend_q;
        cur_i = load ? nxt_i : act_i;
        cur_q = load ? nxt_q : act_q;
    end

    // Capture every strobed pair as the pending pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_i <= 1'b0;
            pend_q <= 1'b0;
        end else if (strobe) begin
            pend_i <= i_in;
            pend_q <= q_in;
        end
    end

    // Replace the pair in use only at a sample boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_i <= 1'b0;
            act_q <= 1'b0;
        end else if (load) begin
            act_i <= nxt_i;
            act_q <= nxt_q;
        end
    end

    // R5: between boundaries the pair in use does not move.
    a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable({act_i, act_q}));

    // R5: a strobe on the boundary edge is taken directly.
    a_r5_fresh_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (load && strobe) |=> (act_i == $past(i_in)) && (act_q == $past(q_in)));

endmodule

// File: rtl/qmix_mixer.sv
// Registered quadrature mixer. Applies the carrier sign and branch selection
// for the effective phase, and forces a 0 output while disabled.
// Assumes the data inputs are already the pair valid at this edge.
module qmix_mixer (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  qmix_pkg::qphase_t eff_phase,
    input  logic              di,
    input  logic              dq,
    output logic              rf_bit,
    output qmix_pkg::qphase_t phase_idx
);
    import qmix_pkg::*;

    // Register the mixed bit together with the phase it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_bit    <= 1'b0;
            phase_idx <= PH_ZERO;
        end else if (en) begin
            rf_bit    <= mix_bit(eff_phase, di, dq);
            phase_idx <= eff_phase;
        end else begin
            rf_bit    <= 1'b0;
        end
    end

    // R7: disabled edges give a 0 output and a held phase.
    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!rf_bit && $stable(phase_idx)));

    // R8: within one enabled carrier period, phase 2 is the complement of phase 0.
    a_r8_balanced_period: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_idx == 2'd2 && $past(phase_idx) == 2'd1 && $past(phase_idx, 2) == 2'd0
         && $past(en) && $past(en, 2) && $past(en, 3))
        |-> (rf_bit == !$past(rf_bit, 2)));

endmodule

// File: rtl/qmix_upconv.sv
// Cartesian coded I/Q digital upconverter, top level.
// Assumes clk is the RF clock at four times the carrier and is shared with
// the coders, so phase, period and sample boundary all come from one source.
module qmix_upconv #(
    parameter int SAMPLE_DIV = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       sync,
    input  logic       strobe,
    input  logic       i_bit,
    input  logic       q_bit,
    output logic       rf_bit,
    output logic [1:0] phase_idx
);
    import qmix_pkg::*;

    qphase_t eff_phase;
    logic    sample_edge;
    logic    cur_i, cur_q;
    qphase_t phase_out;

    qmix_phase_gen #(.SAMPLE_DIV(SAMPLE_DIV)) phase_gen_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .sync       (sync),
        .eff_phase  (eff_phase),
        .sample_edge(sample_edge)
    );

    qmix_sample_latch latch_i (
        .clk   (clk),
        .rst_n (rst_n),
        .strobe(strobe),
        .i_in  (i_bit),
        .q_in  (q_bit),
        .load  (sample_edge),
        .cur_i (cur_i),
        .cur_q (cur_q)
    );

    qmix_mixer mixer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .eff_phase(eff_phase),
        .di       (cur_i),
        .dq       (cur_q),
        .rf_bit   (rf_bit),
        .phase_idx(phase_out)
    );

    assign phase_idx = phase_out;

    // R2: consecutive enabled edges without sync step the reported phase by one.
    a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sync && $past(en) && $past(rst_n))
        |=> (phase_idx == 2'($past(phase_idx) + 2'd1)));

    // R3: an enabled sync edge reports phase 0.
    a_r3_sync_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sync) |=> (phase_idx == 2'd0));

endmodule

// File: tb/qmix_upconv_tb.sv
`timescale 1ns/1ps
module qmix_upconv_tb_top;

    logic clk = 1'b0;
    logic rst_n, en, sync, strobe, i_bit, q_bit;
    logic rf_bit, rf3;
    logic [1:0] phase_idx, idx3;
    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    qmix_upconv dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .sync(sync), .strobe(strobe),
        .i_bit(i_bit), .q_bit(q_bit), .rf_bit(rf_bit), .phase_idx(phase_idx)
    );

    qmix_upconv #(.SAMPLE_DIV(3)) dut_n3_i (
        .clk(clk), .rst_n(rst_n), .en(en), .sync(sync), .strobe(strobe),
        .i_bit(i_bit), .q_bit(q_bit), .rf_bit(rf3), .phase_idx(idx3)
    );

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic drive(input logic s, input logic st, input logic i, input logic q);
        sync = s; strobe = st; i_bit = i; q_bit = q;
    endtask

    // R1: reset state.
    task automatic t_reset;
        rst_n = 1'b0; en = 1'b1; drive(1'b0, 1'b0, 1'b0, 1'b0);
        tick; tick;
        check("R1 rf", {1'b0, rf_bit}, 2'd0);
        check("R1 idx", phase_idx, 2'd0);
        rst_n = 1'b1; en = 1'b0;
        tick;
    endtask

    // R4/R2/R8/R9/R5: one synced carrier period for a given pair, then reuse of the pair.
    task automatic t_pattern(input logic i, input logic q);
        logic [3:0] exp;
        int ones;
        exp = {~q, ~i, q, i};
        ones = 0;
        en = 1'b1; drive(1'b1, 1'b1, i, q);
        for (int k = 0; k < 4; k++) begin
            tick;   // R9: result visible one edge after the inputs
            if (k == 0) drive(1'b0, 1'b0, 1'b0, 1'b0);
            check("R4 rf", {1'b0, rf_bit}, {1'b0, exp[k]});
            check("R2 idx", phase_idx, 2'(k));
            ones += int'(rf_bit);
        end
        check("R8 ones", 2'(ones), 2'd2);
        tick;
        check("R5 reuse", {1'b0, rf_bit}, {1'b0, i});
        check("R2 wrap", phase_idx, 2'd0);
    endtask

    // R5: a pair strobed at phase 1 waits for the next boundary.
    task automatic t_midchange;
        en = 1'b1; drive(1'b1, 1'b1, 1'b1, 1'b1);
        tick; drive(1'b0, 1'b1, 1'b0, 1'b0);
        check("R5 ph0", {1'b0, rf_bit}, 2'd1);
        tick; drive(1'b0, 1'b0, 1'b0, 1'b0);
        check("R5 ph1 old Q", {1'b0, rf_bit}, 2'd1);
        tick; check("R5 ph2 old I", {1'b0, rf_bit}, 2'd0);
        tick; check("R5 ph3 old Q", {1'b0, rf_bit}, 2'd0);
        tick; check("R5 ph0 new I", {1'b0, rf_bit}, 2'd0);
        tick; check("R5 ph1 new Q", {1'b0, rf_bit}, 2'd0);
    endtask

    // R7: disabled edges force 0, hold the phase and ignore sync.
    task automatic t_enable;
        en = 1'b1; drive(1'b1, 1'b1, 1'b0, 1'b1);
        tick; drive(1'b0, 1'b0, 1'b0, 1'b0);
        tick; tick;
        check("R7 pre ph2", {1'b0, rf_bit}, 2'd1);
        en = 1'b0; sync = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick;
            check("R7 off rf", {1'b0, rf_bit}, 2'd0);
            check("R7 off idx", phase_idx, 2'd2);
        end
        en = 1'b1; sync = 1'b0;
        tick; check("R7 resume idx", phase_idx, 2'd3);
        tick; check("R7 resume ph0", {1'b0, rf_bit}, 2'd0);
        check("R7 resume idx0", phase_idx, 2'd0);
    endtask

    // R3: sync at phase 2 realigns, and the strobed pair is used at once.
    task automatic t_sync_mid;
        en = 1'b1; drive(1'b1, 1'b1, 1'b1, 1'b0);
        tick; drive(1'b0, 1'b0, 1'b0, 1'b0);
        tick;
        drive(1'b1, 1'b1, 1'b0, 1'b1);
        tick; drive(1'b0, 1'b0, 1'b0, 1'b0);
        check("R3 idx", phase_idx, 2'd0);
        check("R3 rf new I", {1'b0, rf_bit}, 2'd0);
        tick;
        check("R3 next idx", phase_idx, 2'd1);
        check("R3 rf new Q", {1'b0, rf_bit}, 2'd1);
    endtask

    // R6: with three carrier periods per sample, a new pair waits for period 0.
    task automatic t_div3;
        en = 1'b1; drive(1'b1, 1'b1, 1'b1, 1'b1);
        tick; drive(1'b0, 1'b1, 1'b0, 1'b0);
        check("R6 first", {1'b0, rf3}, 2'd1);
        tick; drive(1'b0, 1'b0, 1'b0, 1'b0);
        tick; tick; tick;
        check("R6 period1 idx", idx3, 2'd0);
        check("R6 period1 held", {1'b0, rf3}, 2'd1);
        for (int k = 0; k < 4; k++) tick;
        check("R6 period2 held", {1'b0, rf3}, 2'd1);
        for (int k = 0; k < 4; k++) tick;
        check("R6 boundary new", {1'b0, rf3}, 2'd0);
        tick;
        check("R6 boundary Q", {1'b0, rf3}, 2'd0);
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        t_reset;
        t_pattern(1'b1, 1'b0);
        t_pattern(1'b0, 1'b1);
        t_pattern(1'b1, 1'b1);
        t_pattern(1'b0, 1'b0);
        t_midchange;
        t_enable;
        t_sync_mid;
        t_div3;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule